// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps track of which register window a processor is using. It holds the current window pointer and a per-window invalid mask. On a call, the pipeline asks for a save. On a return, it asks for a restore. The block works out the neighbouring window, wrapping around the ring of windows, and looks up that window's invalid bit. If the bit is clear, the new pointer is committed on the next clock edge, with no memory traffic. If the bit is set, the pointer stays where it is and the block reports an overflow (for a save) or an underflow (for a restore), so that a handler can spill or fill a window.

Trap-handler software rewrites the invalid mask through a dedicated write port. It does this after it has freed or loaded a window, and then it retries the faulting instruction. When the pipeline enters a trap, the pointer moves to a fresh window regardless of the mask. The block then issues a one-cycle write request so that the trapped PC and next-PC are stored in that window's local registers. The register storage and the spill and fill machinery sit outside this block.

Top module: `regwin_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request after it, `cwp_o` is 0, `mask_o` has only bit 1 set, `trap_o` is 0 and `lr_we_o` is 0.
- R2: A save whose target window (cwp − 1 mod NWIN) has a clear mask bit sets `cwp_o` to that target on the next clock edge, with `trap_o` = 0.
- R3: A restore whose target window (cwp + 1 mod NWIN) has a clear mask bit sets `cwp_o` to that target on the next clock edge, with `trap_o` = 0.
- R4: Pointer arithmetic wraps. A save from window 0 targets window NWIN − 1, and a restore from window NWIN − 1 targets window 0.
- R5: A save whose target window has its mask bit set leaves `cwp_o` unchanged and drives `trap_o` = 1 (overflow) in the following cycle.
- R6: A restore whose target window has its mask bit set leaves `cwp_o` unchanged and drives `trap_o` = 2 (underflow) in the following cycle.
- R7: When save and restore are requested in the same cycle, only the save is performed, with its own validity check and trap code.
- R8: A mask write loads `mask_wdata_i` into `mask_o` on the next edge, with every bit at position NWIN or above forced to 0. A save or restore in the same cycle is checked against the mask value from before the write.
- R9: In a cycle with no save, restore or trap entry, `cwp_o` holds its value and `trap_o` is 0 in the following cycle.
- R10: Trap entry sets `cwp_o` to cwp − 1 mod NWIN whatever the mask holds, and it overrides a simultaneous save or restore. In the following cycle, `lr_we_o` is 1 for exactly that cycle, `lr_win_o` equals the new `cwp_o`, and `lr_pc_o`/`lr_npc_o` carry the `pc_i`/`npc_i` values sampled at entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| save_i | input | 1 | Save request (shift to cwp − 1) |
| restore_i | input | 1 | Restore request (shift to cwp + 1) |
| trap_enter_i | input | 1 | Trap entry strobe |
| pc_i | input | XLEN | PC to preserve on trap entry |
| npc_i | input | XLEN | Next-PC to preserve on trap entry |
| mask_we_i | input | 1 | Invalid-mask write enable |
| mask_wdata_i | input | 32 | Invalid-mask write data |
| cwp_o | output | PW | Current window pointer |
| mask_o | output | 32 | Invalid mask (1 = window invalid) |
| trap_o | output | 2 | 0 none, 1 overflow, 2 underflow |
| lr_we_o | output | 1 | Write request for the new window's locals |
| lr_win_o | output | PW | Window that receives the PC pair |
| lr_pc_o | output | XLEN | PC to store |
| lr_npc_o | output | XLEN | Next-PC to store |

## Verification
The bench runs a six-window instance, which exercises the wrap logic for a ring size that is not a power of two. For every single-window invalid position, it walks the pointer through more than a full lap in each direction. A design with a wrong wrap would land on window 7 or skip window 5. A design that checked the current window's bit instead of the target's would trap one window early or late. The bench also drives save and restore together, where a wrong priority shows up as an underflow code or a forward step. It drives trap entry into an invalid window, where a design that honoured the mask would stall and emit no local-register write. Finally, it writes the mask in the same cycle as a shift, to catch a design that reads the new mask a cycle early.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int MASK_W = 32;

  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_OVF  = 2'd1,
    TRAP_UNF  = 2'd2
  } trap_e;
endpackage

// File: rtl/regwin_step.sv
module regwin_step #(
  parameter int NWIN = 8,
  parameter int PW   = 3
) (
  input  logic [PW-1:0] cur_i,
  output logic [PW-1:0] dec_o,
  output logic [PW-1:0] inc_o
);
  localparam logic [PW-1:0] TOP = PW'(NWIN - 1);

  generate
    if ((1 << PW) == NWIN) begin : g_pow2
      // ring size matches the counter range: natural wrap
      assign dec_o = cur_i - 1'b1;
      assign inc_o = cur_i + 1'b1;
    end else begin : g_wrap
      assign dec_o = (cur_i == '0)  ? TOP : cur_i - 1'b1;
      assign inc_o = (cur_i == TOP) ? '0  : cur_i + 1'b1;
    end
  endgenerate
endmodule

// File: rtl/regwin_mask.sv
module regwin_mask
  import regwin_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MASK_W-1:0] wdata_i,
  output logic [MASK_W-1:0] q_o
);
  localparam logic [MASK_W-1:0] RST_VAL = MASK_W'(2);

  logic [MASK_W-1:0] live;

  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : g_live
      assign live[g] = (g < NWIN);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL & live;
    else if (we_i) q_o <= wdata_i & live;
  end
endmodule

// File: rtl/regwin_trap_entry.sv
module regwin_trap_entry #(
  parameter int PW   = 3,
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enter_i,
  input  logic [PW-1:0]   win_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  output logic            we_o,
  output logic [PW-1:0]   win_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_o <= 1'b0;
    else         we_o <= enter_i;
  end

  // payload only moves on entry; no reset needed
  always_ff @(posedge clk_i) begin
    if (enter_i) begin
      win_o <= win_i;
      pc_o  <= pc_i;
      npc_o <= npc_i;
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter  int NWIN = 8,
  parameter  int XLEN = 32,
  localparam int PW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              trap_enter_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   npc_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic [PW-1:0]     cwp_o,
  output logic [MASK_W-1:0] mask_o,
  output logic [1:0]        trap_o,
  output logic              lr_we_o,
  output logic [PW-1:0]     lr_win_o,
  output logic [XLEN-1:0]   lr_pc_o,
  output logic [XLEN-1:0]   lr_npc_o
);
  logic [PW-1:0] cwp_q, cwp_d, tgt_dec, tgt_inc;
  trap_e         trap_q, trap_d;
  logic          dec_bad, inc_bad;

  regwin_step #(.NWIN(NWIN), .PW(PW)) i_step (
    .cur_i (cwp_q),
    .dec_o (tgt_dec),
    .inc_o (tgt_inc)
  );

  regwin_mask #(.NWIN(NWIN)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .q_o     (mask_o)
  );

  assign dec_bad = mask_o[tgt_dec];
  assign inc_bad = mask_o[tgt_inc];

  // priority: trap entry, then save, then restore
  always_comb begin
    cwp_d  = cwp_q;
    trap_d = TRAP_NONE;
    if (trap_enter_i) begin
      cwp_d = tgt_dec;
    end else if (save_i) begin
      if (dec_bad) trap_d = TRAP_OVF;
      else         cwp_d  = tgt_dec;
    end else if (restore_i) begin
      if (inc_bad) trap_d = TRAP_UNF;
      else         cwp_d  = tgt_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q  <= '0;
      trap_q <= TRAP_NONE;
    end else begin
      cwp_q  <= cwp_d;
      trap_q <= trap_d;
    end
  end

  regwin_trap_entry #(.PW(PW), .XLEN(XLEN)) i_entry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (trap_enter_i),
    .win_i   (tgt_dec),
    .pc_i    (pc_i),
    .npc_i   (npc_i),
    .we_o    (lr_we_o),
    .win_o   (lr_win_o),
    .pc_o    (lr_pc_o),
    .npc_o   (lr_npc_o)
  );

  assign cwp_o  = cwp_q;
  assign trap_o = trap_q;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter  int NWIN = 8,
  parameter  int XLEN = 32,
  localparam int PW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            save_i,
  input logic            restore_i,
  input logic            trap_enter_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] npc_i,
  input logic            mask_we_i,
  input logic [31:0]     mask_wdata_i,
  input logic [PW-1:0]   cwp_o,
  input logic [31:0]     mask_o,
  input logic [1:0]      trap_o,
  input logic            lr_we_o,
  input logic [PW-1:0]   lr_win_o,
  input logic [XLEN-1:0] lr_pc_o,
  input logic [XLEN-1:0] lr_npc_o
);
  function automatic logic [PW-1:0] mdec(input logic [PW-1:0] c);
    return PW'((int'(c) + NWIN - 1) % NWIN);
  endfunction

  function automatic logic [PW-1:0] minc(input logic [PW-1:0] c);
    return PW'((int'(c) + 1) % NWIN);
  endfunction

  AST_SAVE_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !trap_enter_i && !mask_o[mdec(cwp_o)]) |=> (cwp_o == mdec($past(cwp_o)) && trap_o == 2'd0)); // R2
  AST_RESTORE_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !trap_enter_i && !mask_o[minc(cwp_o)]) |=> (cwp_o == minc($past(cwp_o)) && trap_o == 2'd0)); // R3
  AST_WRAP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !trap_enter_i && cwp_o == '0 && !mask_o[NWIN-1]) |=> cwp_o == PW'(NWIN - 1)); // R4
  AST_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !trap_enter_i && mask_o[mdec(cwp_o)]) |=> ($stable(cwp_o) && trap_o == 2'd1)); // R5
  AST_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !trap_enter_i && mask_o[minc(cwp_o)]) |=> ($stable(cwp_o) && trap_o == 2'd2)); // R6
  AST_SAVE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && restore_i && !trap_enter_i) |=> trap_o != 2'd2); // R7
  AST_MASK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o >> NWIN) == 32'd0); // R8
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && !restore_i && !trap_enter_i) |=> ($stable(cwp_o) && trap_o == 2'd0)); // R9
  AST_ENTER_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> (lr_we_o && cwp_o == mdec($past(cwp_o)) && lr_pc_o == $past(pc_i))); // R10
  AST_LR_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lr_we_o |-> lr_win_o == cwp_o); // R10
  AST_LR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_enter_i |=> !lr_we_o); // R10
endmodule

bind regwin_ctrl regwin_chk #(.NWIN(NWIN), .XLEN(XLEN)) i_chk (.*);

// File: tb/test_regwin_ctrl.sv
`timescale 1ns/1ps
module test_regwin_ctrl;
  localparam int N  = 6;
  localparam int PW = 3;
  localparam logic [31:0] LIVE = 32'h3F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save = 0, rest = 0, tent = 0, mwe = 0;
  logic [31:0] mwd = '0, pc = '0, npc = '0;
  logic [PW-1:0] cwp, lr_win;
  logic [31:0] mask, lr_pc, lr_npc;
  logic [1:0]  trap;
  logic        lr_we;

  int checks = 0, errors = 0, seq = 0;
  int m_cwp = 0;
  logic [31:0] m_mask = 32'h2;
  bit done = 0;

  always #2.5 clk = ~clk;

  regwin_ctrl #(.NWIN(N), .XLEN(32)) i_regwin_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .save_i(save), .restore_i(rest),
    .trap_enter_i(tent), .pc_i(pc), .npc_i(npc), .mask_we_i(mwe),
    .mask_wdata_i(mwd), .cwp_o(cwp), .mask_o(mask), .trap_o(trap),
    .lr_we_o(lr_we), .lr_win_o(lr_win), .lr_pc_o(lr_pc), .lr_npc_o(lr_npc)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic r, input logic t, input logic w, input logic [31:0] wd);
    int tgt, e_trap;
    bit e_lr;
    string tag;
    logic [31:0] pcv;
    @(negedge clk);
    seq++;
    pcv = 32'h1000 + 32'(seq) * 8;
    save = s; rest = r; tent = t; mwe = w; mwd = wd; pc = pcv; npc = pcv + 4;
    e_trap = 0; e_lr = 0; tag = "R9";
    if (t) begin
      m_cwp = (m_cwp + N - 1) % N; e_lr = 1; tag = "R10";
    end else if (s) begin
      tgt = (m_cwp + N - 1) % N;
      tag = r ? "R7" : (m_cwp == 0 ? "R4" : "R2");
      if (m_mask[tgt]) begin e_trap = 1; if (!r) tag = "R5"; end
      else m_cwp = tgt;
    end else if (r) begin
      tgt = (m_cwp + 1) % N;
      tag = (m_cwp == N - 1) ? "R4" : "R3";
      if (m_mask[tgt]) begin e_trap = 2; tag = "R6"; end
      else m_cwp = tgt;
    end
    // mask update after the check: the shift saw the old mask
    if (w) begin m_mask = wd & LIVE; if (tag == "R9") tag = "R8"; end
    @(posedge clk); #1;
    chk(tag, "cwp", 32'(cwp), 32'(m_cwp));
    chk(tag, "trap", 32'(trap), 32'(e_trap));
    chk(w ? "R8" : tag, "mask", mask, m_mask);
    chk(tag, "lr_we", 32'(lr_we), 32'(e_lr));
    if (e_lr) begin
      chk("R10", "lr_win", 32'(lr_win), 32'(m_cwp));
      chk("R10", "lr_pc", lr_pc, pcv);
      chk("R10", "lr_npc", lr_npc, pcv + 4);
    end
    save = 0; rest = 0; tent = 0; mwe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "cwp in reset", 32'(cwp), 0);
    chk("R1", "mask in reset", mask, 32'h2);
    chk("R1", "trap in reset", 32'(trap), 0);
    chk("R1", "lr_we in reset", 32'(lr_we), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", "cwp after release", 32'(cwp), 0);
    chk("R1", "mask after release", mask, 32'h2);

    step(0, 0, 0, 0, 0);
    // reset mask: restore from 0 hits window 1
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    // high bits forced to zero
    step(0, 0, 0, 1, 32'hFFFF_FFFF);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(0, 0, 0, 1, 32'h0);
    // write in the same cycle as a shift sees old mask
    step(1, 0, 0, 1, LIVE);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 1, 32'h0);

    for (int b = 0; b < N; b++) begin
      step(0, 0, 0, 1, 32'h1 << b);
      for (int k = 0; k < 2 * N + 1; k++) step(1, 0, 0, 0, 0);
      for (int k = 0; k < 2 * N + 1; k++) step(0, 1, 0, 0, 0);
      for (int k = 0; k < N; k++) step(1, 1, 0, 0, 0);
      // trap entry ignores the mask and beats save/restore
      step(0, 0, 1, 0, 0);
      step(1, 0, 1, 0, 0);
      step(0, 1, 1, 0, 0);
      step(0, 0, 0, 0, 0);
    end
    step(0, 0, 0, 1, LIVE);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule